// File: doc/BRIEF.md
# Region-Aware Serial Address Pointer

This block holds the 16-bit byte pointer used by a serial memory slave. An upstream protocol engine loads a start address and then issues one strobe per data byte, either a write or a read. For each strobe the block returns a registered response one cycle later. The response carries the address that was accessed, a region code for that address, an acknowledge decision and a write-permit flag. The pointer then moves to the next byte.

Address space is split into a configuration store, a small reserved window, an unmapped hole and a set of 256-byte user pages. Each region steps the pointer differently. In the configuration store the pointer advances and then sticks at the last address. In a user page it wraps back to the start of the same page. A refused access leaves the pointer where it was.

Write permission depends on two inputs. A configuration-lock input blocks writes to the configuration store, and a user-write-disable input blocks writes to the user pages. Each permitted write starts a nonvolatile busy window whose length in clock cycles is a parameter. Every strobe that arrives during that window is refused.

Top module: `region_addr_ptr`

## Requirements
- R1: After a synchronous reset, `cur_addr` is 0x8000, and `resp_vld`, `resp_ack`, `resp_wr_en` and `nv_busy` are all 0.
- R2: When `ld_vld` is high at a clock edge, `cur_addr` takes `ld_addr` at that edge and no response is produced. A strobe in the same cycle is ignored.
- R3: `resp_region` codes are:
  - 0: outside 0x8000–0x82FF
  - 1: configuration store, 0x8000–0x8045
  - 2: reserved window, 0x8046–0x804F
  - 3: unmapped hole, 0x8050–0x80FF
  - 4: user page 0, 0x8100–0x81FF
  - 5: user page 1, 0x8200–0x82FF
- R4: A strobe to region 0 or region 3 is answered with `resp_ack`=0, and the pointer does not move.
- R5: An acknowledged access in the configuration store advances the pointer by one, except at 0x8045, where the pointer stays. Repeated writes there keep targeting 0x8045.
- R6: An acknowledged access in a user page increments only the low byte of the pointer. From 0x81FF it goes to 0x8100, and from 0x82FF it goes to 0x8200.
- R7: A write to the reserved window is acknowledged with `resp_wr_en`=0, and the pointer advances by one.
- R8: While `cfg_lock`=1, configuration writes are acknowledged with `resp_wr_en`=0. Reads are unaffected, and `cfg_lock` does not affect user-page writes.
- R9: While `user_wr_dis`=1, user-page writes are acknowledged with `resp_wr_en`=0. User-page reads are still acknowledged, and `user_wr_dis` does not affect configuration writes.
- R10: A response with `resp_wr_en`=1 raises `nv_busy` at the same edge, and `nv_busy` stays high for BUSY_CYC edges. Every strobe sampled while `nv_busy`=1 is answered with `resp_ack`=0, and the pointer is held.
- R11: A strobe at edge t gives `resp_vld`=1 after edge t. `resp_addr` is the pointer value before that edge. If `wr_stb` and `rd_stb` are both high, the access is treated as a write.
- R12: Reads and refused writes never start the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_vld | input | 1 | Load the pointer from ld_addr |
| ld_addr | input | 16 | Start address |
| wr_stb | input | 1 | One data byte written |
| rd_stb | input | 1 | One data byte read |
| cfg_lock | input | 1 | Block writes to the configuration store |
| user_wr_dis | input | 1 | Block writes to the user pages |
| cur_addr | output | 16 | Current pointer |
| resp_vld | output | 1 | Response for the previous strobe |
| resp_ack | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| resp_wr_en | output | 1 | Write permitted to the memory array |
| resp_addr | output | 16 | Address the responded access targeted |
| resp_region | output | 3 | Region code of resp_addr |
| nv_busy | output | 1 | Nonvolatile write in progress |

## Verification
Several rules are checked by assertions on every cycle:
- a strobe during busy is refused;
- a refused access leaves the pointer alone;
- the pointer holds at the last configuration address and wraps at a page end;
- the reserved window never permits a write;
- a permit always comes with an acknowledge and with busy;
- a load lands in the pointer.

Only the bench scenarios can show the exact region decoding of every window edge, the lock and disable masking per region, and the precise length of the busy window. The same applies to the write-over-read priority. These rules are compared against a bench model under random loads and strobes and in directed corner sequences.

// File: rtl/rap_pkg.sv
// Shared region codes for the region-aware address pointer.
package rap_pkg;
    typedef logic [2:0] region_t;
    localparam region_t RG_NONE = 3'd0;  // outside every window
    localparam region_t RG_CFG  = 3'd1;  // configuration store
    localparam region_t RG_RSVD = 3'd2;  // reserved, writes suppressed
    localparam region_t RG_HOLE = 3'd3;  // unmapped, refused
    localparam region_t RG_USER = 3'd4;  // first user page, later pages follow
endpackage

// File: rtl/rap_region_dec.sv
// Region decoder: classifies an address into a region code.
// Assumes CFG_BASE <= CFG_LAST < RSVD_LAST < USER_BASE, USER_BASE page aligned,
// and USER_PAGES <= 4 so the code fits in three bits.
module rap_region_dec
    import rap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_W     = 8,
    parameter int USER_PAGES = 2,
    parameter logic [ADDR_W-1:0] CFG_BASE  = 16'h8000,
    parameter logic [ADDR_W-1:0] CFG_LAST  = 16'h8045,
    parameter logic [ADDR_W-1:0] RSVD_LAST = 16'h804F,
    parameter logic [ADDR_W-1:0] USER_BASE = 16'h8100
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic              mapped,
    output logic              is_cfg,
    output logic              is_user
);
    localparam int HI_W = ADDR_W - PAGE_W;

    logic [USER_PAGES-1:0] page_hit;

    // one comparator per user page on the upper address bits
    for (genvar p = 0; p < USER_PAGES; p++) begin : g_page
        localparam logic [HI_W-1:0] PG_HI = USER_BASE[ADDR_W-1:PAGE_W] + HI_W'(p);
        assign page_hit[p] = (addr[ADDR_W-1:PAGE_W] == PG_HI);
    end

    // priority encode the address windows into one code
    always_comb begin
        region = RG_NONE;
        if (addr >= CFG_BASE && addr <= CFG_LAST) begin
            region = RG_CFG;
        end else if (addr > CFG_LAST && addr <= RSVD_LAST) begin
            region = RG_RSVD;
        end else if (addr > RSVD_LAST && addr < USER_BASE) begin
            region = RG_HOLE;
        end else begin
            for (int p = 0; p < USER_PAGES; p++) begin
                if (page_hit[p]) region = RG_USER + region_t'(p);
            end
        end
    end

    assign is_cfg  = (region == RG_CFG);
    assign is_user = (region >= RG_USER);
    assign mapped  = (region != RG_NONE) && (region != RG_HOLE);
endmodule

// File: rtl/rap_next_ptr.sv
// Next-pointer logic: the address after an acknowledged byte.
// Configuration store saturates at CFG_LAST, user pages wrap inside the page,
// every other region steps by one.
module rap_next_ptr
    import rap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    parameter logic [ADDR_W-1:0] CFG_LAST = 16'h8045
) (
    input  logic [ADDR_W-1:0] addr,
    input  region_t           region,
    output logic [ADDR_W-1:0] nxt
);
    logic [PAGE_W-1:0] low_inc;

    assign low_inc = addr[PAGE_W-1:0] + PAGE_W'(1);

    // select the step rule for the region
    always_comb begin
        if (region == RG_CFG) begin
            nxt = (addr == CFG_LAST) ? addr : addr + ADDR_W'(1);
        end else if (region >= RG_USER) begin
            nxt = {addr[ADDR_W-1:PAGE_W], low_inc};
        end else begin
            nxt = addr + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/rap_busy_timer.sv
// Busy timer: models the nonvolatile byte write time.
// Assumes BUSY_CYC >= 1 and that start is only raised while busy is low.
module rap_busy_timer #(
    parameter int BUSY_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

    logic [CNT_W-1:0] cnt;

    // load on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign busy = (cnt != '0);

    // R10: counter never exceeds its load value
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LOAD);
    // R10: the top never starts a write while one is in progress
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt == '0));
endmodule

// File: rtl/region_addr_ptr.sv
// Region-aware serial address pointer.
// Takes pointer loads and per-byte strobes from a protocol engine and returns a
// registered response (address, region, ack, write permit) one cycle later.
// Assumes strobes are single-cycle pulses and that a load wins over a strobe.
module region_addr_ptr
    import rap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_W     = 8,
    parameter int USER_PAGES = 2,
    parameter int BUSY_CYC   = 16,
    parameter logic [ADDR_W-1:0] CFG_BASE  = 16'h8000,
    parameter logic [ADDR_W-1:0] CFG_LAST  = 16'h8045,
    parameter logic [ADDR_W-1:0] RSVD_LAST = 16'h804F,
    parameter logic [ADDR_W-1:0] USER_BASE = 16'h8100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_vld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              cfg_lock,
    input  logic              user_wr_dis,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              resp_vld,
    output logic              resp_ack,
    output logic              resp_wr_en,
    output logic [ADDR_W-1:0] resp_addr,
    output logic [2:0]        resp_region,
    output logic              nv_busy
);
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_nxt;
    region_t           region;
    logic              mapped, is_cfg, is_user;
    logic              acc, ack_c, permit;

    rap_region_dec #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .USER_PAGES(USER_PAGES),
        .CFG_BASE(CFG_BASE), .CFG_LAST(CFG_LAST),
        .RSVD_LAST(RSVD_LAST), .USER_BASE(USER_BASE)
    ) u_dec (
        .addr(ptr_q), .region(region), .mapped(mapped),
        .is_cfg(is_cfg), .is_user(is_user)
    );

    rap_next_ptr #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CFG_LAST(CFG_LAST)
    ) u_nxt (
        .addr(ptr_q), .region(region), .nxt(ptr_nxt)
    );

    rap_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(permit), .busy(nv_busy)
    );

    // decide acceptance and write permission for this cycle's strobe
    always_comb begin
        acc    = !ld_vld && (wr_stb || rd_stb);
        ack_c  = acc && mapped && !nv_busy;
        permit = ack_c && wr_stb &&
                 ((is_cfg && !cfg_lock) || (is_user && !user_wr_dis));
    end

    // pointer register: load, or step after an acknowledged byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= CFG_BASE;
        end else if (ld_vld) begin
            ptr_q <= ld_addr;
        end else if (ack_c) begin
            ptr_q <= ptr_nxt;
        end
    end

    // response register for the strobe seen this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_vld    <= 1'b0;
            resp_ack    <= 1'b0;
            resp_wr_en  <= 1'b0;
            resp_addr   <= '0;
            resp_region <= RG_NONE;
        end else begin
            resp_vld   <= acc;
            resp_ack   <= ack_c;
            resp_wr_en <= permit;
            if (acc) begin
                resp_addr   <= ptr_q;
                resp_region <= region;
            end
        end
    end

    assign cur_addr = ptr_q;

    // R10: a strobe during busy yields a not-acknowledge
    a_r10_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && nv_busy) |=> (resp_vld && !resp_ack));
    // R4: a refused access leaves the pointer where it was
    a_r4_nack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && !resp_ack) |-> (cur_addr == resp_addr));
    // R5: the last configuration address holds the pointer
    a_r5_cfg_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_ack && resp_addr == CFG_LAST) |-> (cur_addr == CFG_LAST));
    // R6: the end of a user page wraps to its start
    a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_ack && resp_region >= RG_USER && resp_addr[PAGE_W-1:0] == '1)
        |-> (cur_addr == {resp_addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}}));
    // R7: the reserved window never permits a write
    a_r7_rsvd_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_region == RG_RSVD) |-> !resp_wr_en);
    // R8: a write permit always comes with an acknowledge
    a_r8_permit_acked: assert property (@(posedge clk) disable iff (!rst_n)
        resp_wr_en |-> resp_ack);
    // R12: a permitted write is always accompanied by busy
    a_r12_permit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        resp_wr_en |-> nv_busy);
    // R2: a load lands in the pointer and produces no response
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld |=> (cur_addr == $past(ld_addr) && !resp_vld));
endmodule

// File: tb/sim_region_addr_ptr.sv
module sim_region_addr_ptr;
    localparam int B = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_vld = 1'b0;
    logic [15:0] ld_addr = '0;
    logic        wr_stb = 1'b0, rd_stb = 1'b0;
    logic        cfg_lock = 1'b0, user_wr_dis = 1'b0;
    logic [15:0] cur_addr, resp_addr;
    logic        resp_vld, resp_ack, resp_wr_en, nv_busy;
    logic [2:0]  resp_region;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_ptr;
    int          m_cnt;
    logic        mv, ma, mw;
    logic [15:0] m_raddr;
    logic [2:0]  m_rreg;

    region_addr_ptr #(.BUSY_CYC(B)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_vld(ld_vld), .ld_addr(ld_addr),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .cfg_lock(cfg_lock),
        .user_wr_dis(user_wr_dis), .cur_addr(cur_addr), .resp_vld(resp_vld),
        .resp_ack(resp_ack), .resp_wr_en(resp_wr_en), .resp_addr(resp_addr),
        .resp_region(resp_region), .nv_busy(nv_busy)
    );

    always #4 clk = ~clk;

    function automatic logic [2:0] exp_region(input logic [15:0] a);
        if (a >= 16'h8000 && a <= 16'h8045) return 3'd1;
        if (a >= 16'h8046 && a <= 16'h804F) return 3'd2;
        if (a >= 16'h8050 && a <= 16'h80FF) return 3'd3;
        if (a >= 16'h8100 && a <= 16'h81FF) return 3'd4;
        if (a >= 16'h8200 && a <= 16'h82FF) return 3'd5;
        return 3'd0;
    endfunction

    function automatic logic [15:0] exp_next(input logic [15:0] a);
        logic [2:0] rg = exp_region(a);
        if (rg == 3'd1) return (a == 16'h8045) ? a : a + 16'd1;
        if (rg == 3'd4) return (a == 16'h81FF) ? 16'h8100 : a + 16'd1;
        if (rg == 3'd5) return (a == 16'h82FF) ? 16'h8200 : a + 16'd1;
        return a + 16'd1;
    endfunction

    function automatic logic [15:0] corner_addr(input int k);
        case (k)
            0: return 16'h8000;  1: return 16'h8044;  2: return 16'h8045;
            3: return 16'h804E;  4: return 16'h804F;  5: return 16'h80FF;
            6: return 16'h81FE;  7: return 16'h82FE;  8: return 16'h82FF;
            9: return 16'h8300;  default: return 16'h7FFF;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle, update the bench model, compare after the edge
    task automatic step(input logic ld, input logic [15:0] la, input logic w, input logic r);
        ld_vld = ld; ld_addr = la; wr_stb = w; rd_stb = r;
        @(posedge clk);
        mv = 0; ma = 0; mw = 0;
        if (ld) begin
            m_ptr = la;
            if (m_cnt != 0) m_cnt--;
        end else if (w || r) begin
            mv = 1; m_raddr = m_ptr; m_rreg = exp_region(m_ptr);
            ma = (m_cnt == 0) && m_rreg != 3'd0 && m_rreg != 3'd3;
            mw = w && ma && ((m_rreg == 3'd1 && !cfg_lock) ||
                             (m_rreg >= 3'd4 && !user_wr_dis));
            if (ma) m_ptr = exp_next(m_ptr);
            if (mw) m_cnt = B;
            else if (m_cnt != 0) m_cnt--;
        end else if (m_cnt != 0) begin
            m_cnt--;
        end
        #1;
        chk("R11 resp_vld", {15'd0, resp_vld}, {15'd0, mv});
        if (mv) begin
            chk("R4/R10 resp_ack", {15'd0, resp_ack}, {15'd0, ma});
            chk("R8/R9 resp_wr_en", {15'd0, resp_wr_en}, {15'd0, mw});
            chk("R11 resp_addr", resp_addr, m_raddr);
            chk("R3 resp_region", {13'd0, resp_region}, {13'd0, m_rreg});
        end
        chk("R5/R6 cur_addr", cur_addr, m_ptr);
        chk("R10 nv_busy", {15'd0, nv_busy}, {15'd0, 1'(m_cnt != 0)});
        @(negedge clk);
        ld_vld = 0; wr_stb = 0; rd_stb = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 16'h0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_ptr = 16'h8000; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #0;
        // R1 reset state
        chk("R1 cur_addr", cur_addr, 16'h8000);
        chk("R1 resp_vld", {15'd0, resp_vld}, 16'd0);
        chk("R1 resp_ack", {15'd0, resp_ack}, 16'd0);
        chk("R1 resp_wr_en", {15'd0, resp_wr_en}, 16'd0);
        chk("R1 nv_busy", {15'd0, nv_busy}, 16'd0);

        // R5 saturation with reads, R12 reads never busy
        step(1, 16'h8043, 0, 0);
        step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        chk("R5 stays at last cfg", cur_addr, 16'h8045);
        chk("R5 last resp addr", resp_addr, 16'h8045);
        chk("R12 read no busy", {15'd0, nv_busy}, 16'd0);
        // R5 repeated writes keep 0x8045
        step(0, 0, 1, 0); idle(B);
        step(0, 0, 1, 0);
        chk("R5 second write addr", resp_addr, 16'h8045);
        chk("R5 write permit", {15'd0, resp_wr_en}, 16'd1);
        idle(B);

        // R6 page wraps
        step(1, 16'h81FE, 0, 0);
        step(0, 0, 0, 1); step(0, 0, 0, 1);
        chk("R6 wrap page0", cur_addr, 16'h8100);
        step(1, 16'h82FF, 0, 0); step(0, 0, 0, 1);
        chk("R6 wrap page1", cur_addr, 16'h8200);

        // R4 unmapped and outside
        step(1, 16'h8060, 0, 0); step(0, 0, 1, 0);
        chk("R4 hole nack", {15'd0, resp_ack}, 16'd0);
        chk("R4 hole ptr held", cur_addr, 16'h8060);
        chk("R3 hole code", {13'd0, resp_region}, 16'd3);
        step(1, 16'h9000, 0, 0); step(0, 0, 0, 1);
        chk("R4 outside nack", {15'd0, resp_ack}, 16'd0);
        chk("R3 outside code", {13'd0, resp_region}, 16'd0);

        // R7 reserved window
        step(1, 16'h804F, 0, 0); step(0, 0, 1, 0);
        chk("R7 rsvd ack", {15'd0, resp_ack}, 16'd1);
        chk("R7 rsvd no permit", {15'd0, resp_wr_en}, 16'd0);
        chk("R7 rsvd advance", cur_addr, 16'h8050);
        chk("R12 refused no busy", {15'd0, nv_busy}, 16'd0);

        // R8 config lock
        cfg_lock = 1;
        step(1, 16'h8010, 0, 0); step(0, 0, 1, 0);
        chk("R8 locked ack", {15'd0, resp_ack}, 16'd1);
        chk("R8 locked no permit", {15'd0, resp_wr_en}, 16'd0);
        chk("R12 locked no busy", {15'd0, nv_busy}, 16'd0);
        step(1, 16'h8120, 0, 0); step(0, 0, 1, 0);
        chk("R8 lock spares user", {15'd0, resp_wr_en}, 16'd1);
        idle(B);
        cfg_lock = 0;

        // R9 user write disable
        user_wr_dis = 1;
        step(0, 0, 1, 0);
        chk("R9 disabled no permit", {15'd0, resp_wr_en}, 16'd0);
        step(0, 0, 0, 1);
        chk("R9 read still acked", {15'd0, resp_ack}, 16'd1);
        step(1, 16'h8001, 0, 0); step(0, 0, 1, 0);
        chk("R9 cfg unaffected", {15'd0, resp_wr_en}, 16'd1);
        idle(B);
        user_wr_dis = 0;

        // R10 busy window length
        step(1, 16'h8200, 0, 0); step(0, 0, 1, 0);
        chk("R10 busy raised", {15'd0, nv_busy}, 16'd1);
        step(0, 0, 0, 1);
        chk("R10 nack while busy", {15'd0, resp_ack}, 16'd0);
        chk("R10 ptr held", cur_addr, 16'h8201);
        idle(B - 2);
        step(0, 0, 0, 1);
        chk("R10 last busy edge nack", {15'd0, resp_ack}, 16'd0);
        step(0, 0, 0, 1);
        chk("R10 accepted after window", {15'd0, resp_ack}, 16'd1);

        // R11 write priority, R2 load priority
        step(1, 16'h8105, 0, 0); step(0, 0, 1, 1);
        chk("R11 write wins", {15'd0, resp_wr_en}, 16'd1);
        idle(B);
        step(1, 16'h8030, 1, 1);
        chk("R2 load no resp", {15'd0, resp_vld}, 16'd0);
        chk("R2 load value", cur_addr, 16'h8030);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 100;
            if ($urandom % 50 == 0) cfg_lock = ~cfg_lock;
            if ($urandom % 50 == 0) user_wr_dis = ~user_wr_dis;
            if (r < 12) begin
                logic [15:0] a;
                if ($urandom % 2 == 0) a = corner_addr($urandom % 11);
                else a = 16'h7FF0 + 16'($urandom % 16'h0330);
                step(1, a, 0, 0);
            end else if (r < 40) begin
                step(0, 0, 1, ($urandom % 8) == 0);
            end else if (r < 85) begin
                step(0, 0, 0, 1);
            end else begin
                step(0, 0, 0, 0);
            end
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule